// File: doc/BRIEF.md
# Serial-Controller Interrupt Status Register

This block keeps the raw interrupt flags of a two-wire serial bus controller. The bus engine reports what it sees on the bus through single-cycle event pulses and three transmit-path level conditions. The block turns each of these into a sticky status flag. Each flag has its own clear rule. Depending on the flag, a host write of 1 clears it, a write to the controller's data register clears it, turning the controller off clears it, or a bus restart or stop clears it.

The status word is 16 bits wide. Four bits in it are live, and all other bits are always 0. The host supplies a per-bit enable word. A registered interrupt line is high whenever a set flag has its enable bit set.

When a set event and a clear land in the same cycle, the flag stays set, so no event is lost. The one exception is turning the controller off, which always forces the underflow flag low.

Top module: `sb_irq_status`

## Requirements
- R1: After synchronous reset, every bit of `status` is 0 and `irq` is 0.
- R2: The underflow flag is status bit 10. It becomes 1 on the clock edge where `ctrl_en`, `uf_shift_empty`, `uf_txq_empty` and `uf_bytes_left` are all 1. It does not set if any one of the three conditions is 0.
- R3: The underflow flag becomes 0 after an edge where `data_wr` is 1 or `ctrl_en` is 0. While `ctrl_en` is 0 the flag stays 0 even if the set conditions hold. A host write of 1 to bit 10 has no effect.
- R4: The address flag is status bit 9. It becomes 1 after an edge where `match_own`, `match_gcall` or any bit of `match_alt` is 1.
- R5: While `irq_en[9]` is 1, the address flag clears only when the host writes 1 to bit 9. `evt_restart` and `evt_stop` leave it set.
- R6: While `irq_en[9]` is 0, the address flag clears after an edge with `evt_restart` or `evt_stop` high. Host writes to bit 9 have no effect on it.
- R7: The bus-free flag is status bit 8. It is set by `evt_stop` and cleared only by a host write with bit 8 at 1. A host write of 0 to bit 8 leaves it unchanged.
- R8: The access-error flag is status bit 7. It is set by `evt_access_err` and cleared by a host write of 1 to bit 7. A host write of 0 to bit 7 leaves it unchanged.
- R9: If a set condition and a clear (host write, `data_wr`, restart or stop) apply to the same flag in the same cycle, the flag is 1 afterwards.
- R10: Status bits other than 10, 9, 8 and 7 always read 0, whatever is written or signalled.
- R11: `irq` equals the OR over all bits of `status & irq_en`, as both stood one cycle earlier. `irq` therefore follows a status change by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; 0 forces the underflow flag low |
| uf_shift_empty | input | 1 | Transmit shift register is empty |
| uf_txq_empty | input | 1 | Transmit FIFO is empty |
| uf_bytes_left | input | 1 | Bytes remain to be sent |
| match_own | input | 1 | Pulse: primary own address matched |
| match_alt | input | N_ALT | Pulse per alternate own address matched |
| match_gcall | input | 1 | Pulse: all-zero address matched |
| evt_stop | input | 1 | Pulse: stop condition detected |
| evt_restart | input | 1 | Pulse: repeated start detected |
| evt_access_err | input | 1 | Pulse: data-register access error |
| host_wr | input | 1 | Host write strobe to the status register |
| host_wdata | input | STAT_W | Host write data, 1 bits clear their flags |
| data_wr | input | 1 | Host wrote the data register |
| irq_en | input | STAT_W | Per-bit interrupt enables |
| status | output | STAT_W | Raw status word |
| irq | output | 1 | Registered interrupt request |

## Verification
A stimulus applied before clock edge N shows in `status` right after edge N. It shows in `irq` only after edge N+1, because the line is registered from the flags.

For each stimulus, the driver pushes two items into a queue: the expected status word due at cycle N and the expected interrupt level due at cycle N+1. A monitor then compares each item on the falling edge of the cycle it names. The enable word is only changed after two idle cycles, so every pending interrupt expectation is evaluated against the enable value it was computed with.

// File: rtl/sb_irq_pkg.sv
// Shared definitions for the serial-controller interrupt status block.
// Assumes the four flags occupy consecutive status bits starting at FLAG_BASE.
package sb_irq_pkg;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_BASE = 7;

    // Flag index within the live field; position in status = FLAG_BASE + index.
    typedef enum logic [1:0] {
        FLG_ACCERR  = 2'd0,
        FLG_BUSFREE = 2'd1,
        FLG_ADDR    = 2'd2,
        FLG_UNDER   = 2'd3
    } flag_id_e;

    // Per-flag control: set request, conditional clear, dominant forced clear.
    typedef struct packed {
        logic set;
        logic clr;
        logic kill;
    } flag_ctl_t;

    function automatic int flag_pos(input flag_id_e id);
        return FLAG_BASE + int'(id);
    endfunction

endpackage

// File: rtl/sb_irq_flag.sv
// One sticky status flag.
// Priority: kill (forced clear) > set > clear > hold.
// Assumes set/clr/kill are already qualified by the decode stage.
module sb_irq_flag (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sb_irq_pkg::flag_ctl_t ctl_i,
    output logic                  flag_o
);

    logic flag_q;
    logic flag_d;

    // Next-state selection with set-over-clear priority.
    always_comb begin
        flag_d = flag_q;
        if (ctl_i.kill) begin
            flag_d = 1'b0;
        end else if (ctl_i.set) begin
            flag_d = 1'b1;
        end else if (ctl_i.clr) begin
            flag_d = 1'b0;
        end
    end

    // Flag storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/sb_irq_ctl.sv
// Decodes bus-engine events and host accesses into set/clear/kill per flag.
// Assumes event inputs are single-cycle pulses and w1c_i is already gated by
// the host write strobe.
module sb_irq_ctl #(
    parameter int N_ALT = 3
) (
    input  logic                                           ctrl_en,
    input  logic                                           uf_shift_empty,
    input  logic                                           uf_txq_empty,
    input  logic                                           uf_bytes_left,
    input  logic                                           match_own,
    input  logic [N_ALT-1:0]                               match_alt,
    input  logic                                           match_gcall,
    input  logic                                           evt_stop,
    input  logic                                           evt_restart,
    input  logic                                           evt_access_err,
    input  logic [sb_irq_pkg::NUM_FLAGS-1:0]               w1c_i,
    input  logic                                           data_wr,
    input  logic                                           addr_irq_en,
    output sb_irq_pkg::flag_ctl_t [sb_irq_pkg::NUM_FLAGS-1:0] ctl_o
);
    import sb_irq_pkg::*;

    logic any_addr_match;
    logic bus_boundary;
    logic underflow_now;

    // Shared event terms.
    always_comb begin
        any_addr_match = match_own | (|match_alt) | match_gcall;
        bus_boundary   = evt_stop | evt_restart;
        underflow_now  = uf_shift_empty & uf_txq_empty & uf_bytes_left;
    end

    // Per-flag clear rules.
    always_comb begin
        ctl_o = '0;

        ctl_o[FLG_UNDER].set  = underflow_now;
        ctl_o[FLG_UNDER].clr  = data_wr;
        ctl_o[FLG_UNDER].kill = ~ctrl_en;

        ctl_o[FLG_ADDR].set   = any_addr_match;
        ctl_o[FLG_ADDR].clr   = addr_irq_en ? w1c_i[FLG_ADDR] : bus_boundary;

        ctl_o[FLG_BUSFREE].set = evt_stop;
        ctl_o[FLG_BUSFREE].clr = w1c_i[FLG_BUSFREE];

        ctl_o[FLG_ACCERR].set = evt_access_err;
        ctl_o[FLG_ACCERR].clr = w1c_i[FLG_ACCERR];
    end

endmodule

// File: rtl/sb_irq_line.sv
// Masks the status word with the enables and registers the OR as the
// interrupt request. Assumes status and enable words have equal width.
module sb_irq_line #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_o
);

    logic [W-1:0] masked;
    logic         irq_q;

    // Combine every enabled, set flag.
    always_comb begin
        masked = status_i & enable_i;
    end

    // Register the request one cycle behind the status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |masked;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sb_irq_status.sv
// Raw interrupt status register of a two-wire serial bus controller.
// Holds four sticky flags at fixed bit positions, applies each flag's own
// clear rule and drives one registered interrupt line.
// Assumes STAT_W covers FLAG_BASE + NUM_FLAGS bits.
module sb_irq_status #(
    parameter int STAT_W = 16,
    parameter int N_ALT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              uf_shift_empty,
    input  logic              uf_txq_empty,
    input  logic              uf_bytes_left,
    input  logic              match_own,
    input  logic [N_ALT-1:0]  match_alt,
    input  logic              match_gcall,
    input  logic              evt_stop,
    input  logic              evt_restart,
    input  logic              evt_access_err,
    input  logic              host_wr,
    input  logic [STAT_W-1:0] host_wdata,
    input  logic              data_wr,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    import sb_irq_pkg::*;

    localparam int LIVE_LO = FLAG_BASE;
    localparam int ADDR_EN_BIT = FLAG_BASE + int'(FLG_ADDR);

    logic [NUM_FLAGS-1:0]            w1c;
    logic [NUM_FLAGS-1:0]            flag_q;
    flag_ctl_t [NUM_FLAGS-1:0]       ctl;
    logic                            unused_wdata;

    // Host write-1-to-clear bits for the live field.
    always_comb begin
        w1c = host_wr ? host_wdata[LIVE_LO +: NUM_FLAGS] : '0;
    end

    // Bits outside the live field are write-ignored.
    assign unused_wdata = ^host_wdata;

    sb_irq_ctl #(
        .N_ALT(N_ALT)
    ) ctl_i (
        .ctrl_en        (ctrl_en),
        .uf_shift_empty (uf_shift_empty),
        .uf_txq_empty   (uf_txq_empty),
        .uf_bytes_left  (uf_bytes_left),
        .match_own      (match_own),
        .match_alt      (match_alt),
        .match_gcall    (match_gcall),
        .evt_stop       (evt_stop),
        .evt_restart    (evt_restart),
        .evt_access_err (evt_access_err),
        .w1c_i          (w1c),
        .data_wr        (data_wr),
        .addr_irq_en    (irq_en[ADDR_EN_BIT]),
        .ctl_o          (ctl)
    );

    // One flag cell per live status bit.
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        sb_irq_flag flag_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl_i  (ctl[gi]),
            .flag_o (flag_q[gi])
        );
    end

    // Place the live flags into the status word; other bits are zero.
    always_comb begin
        status = '0;
        status[LIVE_LO +: NUM_FLAGS] = flag_q;
    end

    sb_irq_line #(
        .W(STAT_W)
    ) line_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (irq_en),
        .irq_o    (irq)
    );

endmodule

// File: rtl/sb_irq_status_chk.sv
// Property checker for sb_irq_status, attached with bind.
// Observes ports only; assumes synchronous active-low reset.
module sb_irq_status_chk #(
    parameter int STAT_W = 16,
    parameter int N_ALT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_en,
    input logic              uf_shift_empty,
    input logic              uf_txq_empty,
    input logic              uf_bytes_left,
    input logic              match_own,
    input logic [N_ALT-1:0]  match_alt,
    input logic              match_gcall,
    input logic              evt_stop,
    input logic              evt_restart,
    input logic              evt_access_err,
    input logic              host_wr,
    input logic [STAT_W-1:0] host_wdata,
    input logic              data_wr,
    input logic [STAT_W-1:0] irq_en,
    input logic [STAT_W-1:0] status,
    input logic              irq
);
    localparam int B_UF = 10;
    localparam int B_AD = 9;
    localparam int B_BF = 8;
    localparam int B_AE = 7;
    localparam logic [STAT_W-1:0] LIVE = STAT_W'(16'h0780);

    logic uf_cond;
    logic any_match;
    assign uf_cond   = uf_shift_empty & uf_txq_empty & uf_bytes_left;
    assign any_match = match_own | (|match_alt) | match_gcall;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status == '0 && !irq));

    a_r2_uf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && uf_cond) |=> status[B_UF]);

    a_r3_uf_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !status[B_UF]);

    a_r3_uf_datawr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !uf_cond) |=> !status[B_UF]);

    a_r4_addr_set: assert property (@(posedge clk) disable iff (!rst_n)
        any_match |=> status[B_AD]);

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_AD] && irq_en[B_AD] && !(host_wr && host_wdata[B_AD]))
        |=> status[B_AD]);

    a_r6_addr_bus_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en[B_AD] && (evt_stop || evt_restart) && !any_match)
        |=> !status[B_AD]);

    a_r7_bf_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stop |=> status[B_BF]);

    a_r7_bf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_BF] && !(host_wr && host_wdata[B_BF])) |=> status[B_BF]);

    a_r8_ae_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_access_err |=> status[B_AE]);

    a_r8_ae_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[B_AE] && !evt_access_err) |=> !status[B_AE]);

    a_r10_dead_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~LIVE) == '0);

    a_r11_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq == $past(|(status & irq_en))));

endmodule

bind sb_irq_status sb_irq_status_chk #(
    .STAT_W(STAT_W),
    .N_ALT (N_ALT)
) chk_i (.*);

// File: tb/sb_irq_status_tb_top.sv
// Scoreboard bench for sb_irq_status: driver pushes expectations, a
// falling-edge monitor compares them in the cycle they fall due.
module sb_irq_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STAT_W = 16;
    localparam int N_ALT  = 3;

    typedef struct {
        int          due;
        bit          is_irq;
        logic [15:0] value;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_en = 1'b1;
    logic uf_shift_empty = 1'b0, uf_txq_empty = 1'b0, uf_bytes_left = 1'b0;
    logic match_own = 1'b0, match_gcall = 1'b0;
    logic [N_ALT-1:0] match_alt = '0;
    logic evt_stop = 1'b0, evt_restart = 1'b0, evt_access_err = 1'b0;
    logic host_wr = 1'b0, data_wr = 1'b0;
    logic [STAT_W-1:0] host_wdata = '0;
    logic [STAT_W-1:0] irq_en = '0;
    logic [STAT_W-1:0] status;
    logic irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sb_irq_status #(.STAT_W(STAT_W), .N_ALT(N_ALT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .uf_shift_empty(uf_shift_empty), .uf_txq_empty(uf_txq_empty),
        .uf_bytes_left(uf_bytes_left), .match_own(match_own),
        .match_alt(match_alt), .match_gcall(match_gcall),
        .evt_stop(evt_stop), .evt_restart(evt_restart),
        .evt_access_err(evt_access_err), .host_wr(host_wr),
        .host_wdata(host_wdata), .data_wr(data_wr), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    // Monitor: compare every expectation due in the current cycle.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                checks++;
                if (q[i].is_irq) begin
                    if (irq !== q[i].value[0]) begin
                        errors++;
                        $display("FAIL %s irq: actual %0b expected %0b (cycle %0d)",
                                 q[i].tag, irq, q[i].value[0], cyc);
                    end
                end else if (status !== q[i].value) begin
                    errors++;
                    $display("FAIL %s status: actual %h expected %h (cycle %0d)",
                             q[i].tag, status, q[i].value, cyc);
                end
                q.delete(i);
            end
        end
    end

    task automatic clear_stim();
        uf_shift_empty = 0; uf_txq_empty = 0; uf_bytes_left = 0;
        match_own = 0; match_alt = '0; match_gcall = 0;
        evt_stop = 0; evt_restart = 0; evt_access_err = 0;
        host_wr = 0; host_wdata = '0; data_wr = 0;
    endtask

    // Driver: stimulus already applied; push status (next edge) and irq (edge after).
    task automatic step(input logic [15:0] exp_st, input string tag);
        exp_t e;
        e.due = cyc + 1; e.is_irq = 0; e.value = exp_st; e.tag = tag;
        q.push_back(e);
        e.due = cyc + 2; e.is_irq = 1; e.value = {15'd0, |(exp_st & irq_en)}; e.tag = "R11";
        q.push_back(e);
        @(posedge clk); #1;
        clear_stim();
    endtask

    task automatic set_en(input logic [15:0] v);
        repeat (2) begin
            @(posedge clk); #1;
        end
        irq_en = v;
    endtask

    task automatic host_write(input logic [15:0] v);
        host_wr = 1; host_wdata = v;
    endtask

    task automatic uf_all();
        uf_shift_empty = 1; uf_txq_empty = 1; uf_bytes_left = 1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if (status !== '0 || irq !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %h/%0b expected 0000/0", status, irq);
        end
        @(posedge clk); #1;

        // R2: partial condition does not set; full condition does.
        uf_shift_empty = 1; uf_txq_empty = 1; step(16'h0000, "R2");
        uf_all();                              step(16'h0400, "R2");
        // R3: host write ignored, data write clears, disable clears and blocks.
        host_write(16'h0400);                  step(16'h0400, "R3");
        data_wr = 1;                           step(16'h0000, "R3");
        uf_all();                              step(16'h0400, "R2");
        ctrl_en = 0;                           step(16'h0000, "R3");
        uf_all();                              step(16'h0000, "R3");
        ctrl_en = 1;

        // R4/R6: address flag with its enable off.
        match_own = 1;                         step(16'h0200, "R4");
        evt_restart = 1;                       step(16'h0000, "R6");
        match_alt = 3'b010;                    step(16'h0200, "R4");
        host_write(16'h0200);                  step(16'h0200, "R6");
        evt_stop = 1;                          step(16'h0100, "R6");
        host_write(16'h0000);                  step(16'h0100, "R7");
        host_write(16'h0100);                  step(16'h0000, "R7");
        match_gcall = 1;                       step(16'h0200, "R4");
        evt_stop = 1;                          step(16'h0100, "R6");
        host_write(16'h0100);                  step(16'h0000, "R7");

        // R5: address flag with its enable on.
        set_en(16'h0200);
        match_alt = 3'b100;                    step(16'h0200, "R4");
        evt_restart = 1;                       step(16'h0200, "R5");
        evt_stop = 1;                          step(16'h0300, "R5");
        host_write(16'h0000);                  step(16'h0300, "R5");
        host_write(16'h0200);                  step(16'h0100, "R5");
        host_write(16'h0100);                  step(16'h0000, "R7");

        // R8: access error.
        set_en(16'h0080);
        evt_access_err = 1;                    step(16'h0080, "R8");
        host_write(16'h0000);                  step(16'h0080, "R8");
        host_write(16'h0080);                  step(16'h0000, "R8");

        // R9: set beats same-cycle clear.
        evt_access_err = 1; host_write(16'h0080); step(16'h0080, "R9");
        host_write(16'h0080);                  step(16'h0000, "R8");
        evt_stop = 1; host_write(16'h0100);    step(16'h0100, "R9");
        match_own = 1; evt_stop = 1;           step(16'h0300, "R9");
        uf_all(); data_wr = 1;                 step(16'h0700, "R9");
        data_wr = 1; host_write(16'hFFFF); evt_restart = 1; step(16'h0000, "R3");

        // R10: every source at once; dead bits stay zero.
        uf_all(); match_own = 1; evt_stop = 1; evt_access_err = 1;
        host_write(16'hFFFF);                  step(16'h0780, "R10");
        // R11: enables off leave flags set but drop the line.
        set_en(16'h0000);
                                               step(16'h0780, "R11");
        set_en(16'hF87F);
                                               step(16'h0780, "R10");
        set_en(16'h0400);
                                               step(16'h0780, "R11");
        data_wr = 1; host_write(16'hFFFF); evt_restart = 1; step(16'h0000, "R7");

        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule